// File: doc/BRIEF.md
# Real-Time Clock Extended Control and Status Register

This block is one 8-bit control and status register for a real-time clock. Software reaches it through a plain write strobe with write data and a read data bus that always shows the current value. Three event flags live in the register: wake-up alarm, kickstart and RAM-clear. Hardware sets them. Software clears a flag by writing 0 to it, and software can write 1 to force a flag and so raise an interrupt condition on purpose.

The register also holds a power-pin control bit. While that bit is 0, the block enables an active-low power output. While it is 1, the output floats, which the block models as a deasserted output enable. Hardware clears this bit whenever an event flag and its matching enable are both set. An update-in-progress status bit rises on a lead strobe from the update sequencer and falls when the update-done strobe arrives. A battery-valid input is shown as a read-only bit.

The RAM-clear input is asynchronous. It is synchronised into the register clock domain, and only its falling edges count, and only while the RAM-clear enable is high. The timekeeping counters, the alarm compare, the battery monitor and the RAM-clear action itself all sit outside this block.

Top module: `rtc_xctl_reg`

## Requirements
- R1: While rst_ni is low, every writable bit and the in-progress bit read 0, and pwr_oe_o is 1.
- R2: Read data bit 7 always equals bat_ok_i, and writes do not change it.
- R3: Bits 5 (burst enable, also output on burst_en_o) and 4 (spare) take wdata_i on a write and otherwise hold their value. Neither bit affects any other bit or output.
- R4: A write stores wdata_i bits 2..0 into the RAM-clear flag (bit 2), the wake-up flag (bit 1) and the kickstart flag (bit 0). Writing 0 clears a flag and writing 1 forces it.
- R5: wake_evt_i sets bit 1 and kick_evt_i sets bit 0 at the next clock edge. A hardware set wins over a write of 0 to the same flag in the same cycle.
- R6: A falling edge of rclr_ni is seen on the third rising edge after the first edge that samples it low. If rclr_en_i is 1 at that edge, bit 2 is set. If rclr_en_i is 0, bit 2 is unchanged.
- R7: Bit 3 (power control) takes wdata_i[3] on a write. If, before an edge, (bit 1 and wake_ie_i) or (bit 0 and kick_en_i) holds, then bit 3 becomes 0 at that edge, and this overrides any write.
- R8: pwr_oe_o is 1 exactly when bit 3 is 0.
- R9: Bit 6 goes to 1 on the edge after upd_lead_i and to 0 on the edge after upd_done_i. If both strobes arrive in the same cycle, the lead strobe wins. Writes do not change bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Current register value |
| bat_ok_i | input | 1 | Auxiliary battery valid level |
| upd_lead_i | input | 1 | One-cycle strobe at the lead point before an update |
| upd_done_i | input | 1 | One-cycle strobe when the update finishes |
| wake_evt_i | input | 1 | Wake-up alarm event strobe |
| kick_evt_i | input | 1 | Kickstart event strobe |
| rclr_ni | input | 1 | Asynchronous RAM-clear request, active on falling edge |
| rclr_en_i | input | 1 | RAM-clear detection enable |
| wake_ie_i | input | 1 | Wake-up interrupt enable |
| kick_en_i | input | 1 | Kickstart enable |
| pwr_oe_o | output | 1 | Enable for driving the power pin low |
| burst_en_o | output | 1 | Burst mode enable bit |

## Verification
The assertions assume that the update strobes and event strobes are level samples taken at each rising edge. They make no assumption about pulse width. The falling-edge check assumes that rclr_ni changes at most once per two register cycles after synchronisation. The bench meets this by holding rclr_ni for several cycles in the directed part and by toggling it with low probability in the random part. All inputs change only on the falling clock edge, so every edge sees settled values. The random phase still lets strobes coincide with writes and with each other.

// File: rtl/rtc_xctl_pkg.sv
package rtc_xctl_pkg;
  localparam int REG_W     = 8;
  localparam int N_FLAGS   = 3;
  localparam int BIT_KICK  = 0;
  localparam int BIT_WAKE  = 1;
  localparam int BIT_RCLR  = 2;
  localparam int BIT_PWR   = 3;
  localparam int BIT_SPARE = 4;
  localparam int BIT_BURST = 5;
  localparam int BIT_INCR  = 6;
  localparam int BIT_BAT   = 7;
endpackage

// File: rtl/rtc_xctl_flag.sv
module rtc_xctl_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic q_o
);
  logic q_q;

  // hardware set outranks software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= 1'b0;
    else if (set_i)  q_q <= 1'b1;
    else if (wr_i)   q_q <= wdata_i;
  end

  assign q_o = q_q;

  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  a_r4_write_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i && !set_i) |=> !q_o);
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/rtc_xctl_fall_det.sv
module rtc_xctl_fall_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic fall_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b1;
    else         sync_q[0] <= async_i;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= 1'b1;
      else         sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[LAST];
  end

  assign fall_o = prev_q & ~sync_q[LAST];

  a_r6_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/rtc_xctl_incr_track.sv
module rtc_xctl_incr_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lead_i,
  input  logic done_i,
  output logic busy_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_q <= 1'b0;
    else if (lead_i) busy_q <= 1'b1;
    else if (done_i) busy_q <= 1'b0;
  end

  assign busy_o = busy_q;

  a_r9_lead_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_i |=> busy_o);
  a_r9_done_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !lead_i) |=> !busy_o);
  a_r9_quiet_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && !lead_i) |=> $stable(busy_o));
endmodule

// File: rtl/rtc_xctl_reg.sv
module rtc_xctl_reg
  import rtc_xctl_pkg::*;
#(
  parameter int RCLR_SYNC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             bat_ok_i,
  input  logic             upd_lead_i,
  input  logic             upd_done_i,
  input  logic             wake_evt_i,
  input  logic             kick_evt_i,
  input  logic             rclr_ni,
  input  logic             rclr_en_i,
  input  logic             wake_ie_i,
  input  logic             kick_en_i,
  output logic             pwr_oe_o,
  output logic             burst_en_o
);
  logic [N_FLAGS-1:0] flag_set;
  logic [N_FLAGS-1:0] flag_q;
  logic               rclr_fall;
  logic               incr_q;
  logic               pwr_q;
  logic               burst_q;
  logic               spare_q;
  logic               pwr_kill;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i[BIT_BAT:BIT_INCR];

  rtc_xctl_fall_det #(.SYNC_STAGES(RCLR_SYNC)) u_rclr_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (rclr_ni),
    .fall_o  (rclr_fall)
  );

  assign flag_set[BIT_KICK] = kick_evt_i;
  assign flag_set[BIT_WAKE] = wake_evt_i;
  assign flag_set[BIT_RCLR] = rclr_fall & rclr_en_i;

  for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
    rtc_xctl_flag u_flag (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (flag_set[f]),
      .wr_i    (wr_en_i),
      .wdata_i (wdata_i[f]),
      .q_o     (flag_q[f])
    );
  end

  rtc_xctl_incr_track u_incr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lead_i (upd_lead_i),
    .done_i (upd_done_i),
    .busy_o (incr_q)
  );

  assign pwr_kill = (flag_q[BIT_WAKE] & wake_ie_i) | (flag_q[BIT_KICK] & kick_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q   <= 1'b0;
      burst_q <= 1'b0;
      spare_q <= 1'b0;
    end else begin
      if (pwr_kill)     pwr_q <= 1'b0;
      else if (wr_en_i) pwr_q <= wdata_i[BIT_PWR];
      if (wr_en_i) begin
        burst_q <= wdata_i[BIT_BURST];
        spare_q <= wdata_i[BIT_SPARE];
      end
    end
  end

  assign rdata_o    = {bat_ok_i, incr_q, burst_q, spare_q, pwr_q, flag_q};
  assign pwr_oe_o   = ~pwr_q;
  assign burst_en_o = burst_q;

  a_r7_pwr_autoclr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdata_o[BIT_WAKE] && wake_ie_i) || (rdata_o[BIT_KICK] && kick_en_i)) |=> pwr_oe_o);
  a_r7_pwr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !pwr_kill) |=> $stable(pwr_oe_o));
  a_r6_rclr_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rclr_en_i && !wr_en_i) |=> $stable(rdata_o[BIT_RCLR]));
  a_r3_burst_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(burst_en_o));
endmodule

// File: tb/rtc_xctl_reg_bench.sv
`timescale 1ns/1ps
module rtc_xctl_reg_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       bat_ok_i = 1'b1;
  logic       upd_lead_i = 1'b0;
  logic       upd_done_i = 1'b0;
  logic       wake_evt_i = 1'b0;
  logic       kick_evt_i = 1'b0;
  logic       rclr_ni = 1'b1;
  logic       rclr_en_i = 1'b0;
  logic       wake_ie_i = 1'b0;
  logic       kick_en_i = 1'b0;
  logic       pwr_oe_o;
  logic       burst_en_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  rtc_xctl_reg u_rtc_xctl_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .bat_ok_i(bat_ok_i), .upd_lead_i(upd_lead_i),
    .upd_done_i(upd_done_i), .wake_evt_i(wake_evt_i), .kick_evt_i(kick_evt_i),
    .rclr_ni(rclr_ni), .rclr_en_i(rclr_en_i), .wake_ie_i(wake_ie_i),
    .kick_en_i(kick_en_i), .pwr_oe_o(pwr_oe_o), .burst_en_o(burst_en_o)
  );

  // behavioural reference state
  bit m_kick, m_wake, m_rclr, m_pwr, m_spare, m_burst, m_incr;
  bit rclr_hist[$] = '{1'b1, 1'b1, 1'b1};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      {m_kick, m_wake, m_rclr, m_pwr, m_spare, m_burst, m_incr} = '0;
      rclr_hist = '{1'b1, 1'b1, 1'b1};
    end else begin
      bit fall, kill, n_kick, n_wake, n_rclr;
      // rclr_hist[0] newest sample, [2] oldest of three
      fall = rclr_hist[2] && !rclr_hist[1];
      kill = (m_wake && wake_ie_i) || (m_kick && kick_en_i);
      n_kick = kick_evt_i ? 1'b1 : (wr_en_i ? wdata_i[0] : m_kick);
      n_wake = wake_evt_i ? 1'b1 : (wr_en_i ? wdata_i[1] : m_wake);
      n_rclr = (fall && rclr_en_i) ? 1'b1 : (wr_en_i ? wdata_i[2] : m_rclr);
      if (kill) m_pwr = 1'b0;
      else if (wr_en_i) m_pwr = wdata_i[3];
      if (wr_en_i) begin
        m_spare = wdata_i[4];
        m_burst = wdata_i[5];
      end
      if (upd_lead_i) m_incr = 1'b1;
      else if (upd_done_i) m_incr = 1'b0;
      m_kick = n_kick; m_wake = n_wake; m_rclr = n_rclr;
      rclr_hist.push_front(rclr_ni);
      void'(rclr_hist.pop_back());
    end
    #1;
    if (!finished) begin
      if (!rst_ni) begin
        check("R1 reset value", int'(rdata_o[6:0]), 0);
        check("R1 reset pwr_oe", int'(pwr_oe_o), 1);
      end else begin
        check("R2 battery bit", int'(rdata_o[7]), int'(bat_ok_i));
        check("R9 in-progress bit", int'(rdata_o[6]), int'(m_incr));
        check("R3 burst bit", int'(rdata_o[5]), int'(m_burst));
        check("R3 burst_en_o", int'(burst_en_o), int'(m_burst));
        check("R3 spare bit", int'(rdata_o[4]), int'(m_spare));
        check("R7 power control bit", int'(rdata_o[3]), int'(m_pwr));
        check("R8 pwr_oe_o", int'(pwr_oe_o), int'(!m_pwr));
        check("R6 R4 ram-clear flag", int'(rdata_o[2]), int'(m_rclr));
        check("R5 R4 wake flag", int'(rdata_o[1]), int'(m_wake));
        check("R5 R4 kick flag", int'(rdata_o[0]), int'(m_kick));
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk_i); wr_en_i = 1'b1; wdata_i = v;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    // R3 R4 R7: write all ones, then all zeros
    wr(8'hFF); idle(2);
    wr(8'h00); idle(2);
    wr(8'h30); wr(8'h10); idle(1);
    // R2: write of bit 7 ignored, battery level followed
    wr(8'h80); bat_ok_i = 1'b0; idle(3); bat_ok_i = 1'b1; idle(1);
    // R5: events, and event against write-0 in the same cycle
    @(negedge clk_i); wake_evt_i = 1'b1;
    @(negedge clk_i); wake_evt_i = 1'b0;
    @(negedge clk_i); kick_evt_i = 1'b1; wr_en_i = 1'b1; wdata_i = 8'h00;
    @(negedge clk_i); kick_evt_i = 1'b0; wr_en_i = 1'b0;
    idle(2); wr(8'h00);
    // R7: power bit cleared by wake flag with enable, write of 1 overridden
    wr(8'h08); idle(2);
    wake_ie_i = 1'b1; wr(8'h0A); idle(1); wr(8'h0A); idle(3);
    wake_ie_i = 1'b0; wr(8'h08); kick_en_i = 1'b1; idle(1);
    @(negedge clk_i); kick_evt_i = 1'b1;
    @(negedge clk_i); kick_evt_i = 1'b0;
    idle(3); kick_en_i = 1'b0; wr(8'h00);
    // R6: falling edge with enable low, then high
    rclr_en_i = 1'b0; @(negedge clk_i); rclr_ni = 1'b0; idle(6); rclr_ni = 1'b1; idle(6);
    rclr_en_i = 1'b1; @(negedge clk_i); rclr_ni = 1'b0; idle(6); rclr_ni = 1'b1; idle(6);
    wr(8'h00); rclr_en_i = 1'b0;
    // R9: lead, done, both together
    @(negedge clk_i); upd_lead_i = 1'b1;
    @(negedge clk_i); upd_lead_i = 1'b0; idle(3);
    @(negedge clk_i); upd_done_i = 1'b1;
    @(negedge clk_i); upd_done_i = 1'b0; idle(1);
    @(negedge clk_i); upd_lead_i = 1'b1; upd_done_i = 1'b1;
    @(negedge clk_i); upd_lead_i = 1'b0; upd_done_i = 1'b0; idle(2);
    wr(8'h40); idle(1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_i);
      wr_en_i    = ($urandom_range(0, 5) == 0);
      wdata_i    = 8'($urandom);
      wake_evt_i = ($urandom_range(0, 19) == 0);
      kick_evt_i = ($urandom_range(0, 19) == 0);
      upd_lead_i = ($urandom_range(0, 15) == 0);
      upd_done_i = ($urandom_range(0, 11) == 0);
      if ($urandom_range(0, 9) == 0) rclr_ni = ~rclr_ni;
      if ($urandom_range(0, 31) == 0) rclr_en_i = ~rclr_en_i;
      if ($urandom_range(0, 31) == 0) wake_ie_i = ~wake_ie_i;
      if ($urandom_range(0, 31) == 0) kick_en_i = ~kick_en_i;
      if ($urandom_range(0, 63) == 0) bat_ok_i = ~bat_ok_i;
    end
    @(negedge clk_i);
    {wr_en_i, wake_evt_i, kick_evt_i, upd_lead_i, upd_done_i} = '0;
    idle(4);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule